// File: doc/BRIEF.md
# Boundary Scan Data Register for Bidirectional Pins

This block is the boundary data register that sits between the test data input and the test data output of a scan port. Every bidirectional pin gets three scan cells: one observes the value arriving from the pad, one holds the value to drive onto the pad, and one holds that pad's driver enable. Pins that only receive get a single observing cell. Pins that only drive get a single drive cell. Three fixed cells that belong to no pin complete the chain. Two sit at the output end and control the scan output's own driver and data. One sits at the input end and serves as an update-control bit. The program, configuration-clock and done pins have no cells.

Each cell has a 2:1 multiplexer that selects parallel capture data or the serial bit from its upstream neighbour. The multiplexer feeds a shift flip-flop. Drive and enable cells add an update stage that loads from the shift flip-flop. An external TAP controller supplies the strobes: a clock-DR enable, a shift/capture select, an update strobe and the external-test mode. While external-test mode is set, the update stages drive the pads. Otherwise the core's signals pass through unchanged. The scan path is a plain serial stream, so it has no valid/ready handshake, and every control pin is a plain level.

Top module: `bscan_chain`

## Requirements
- R1: An active-low asynchronous reset clears every shift flip-flop and every update stage, so `tdo` reads 0 and the auxiliary outputs read 0.
- R2: The chain length is 3·N_BIDIR + N_IN + N_OUT + 3. A bit presented on `tdi` first appears on `tdo` after exactly that many shift clocks.
- R3: On a rising `tck` with `dr_clk_en`=1 and `shift_dr`=1, every bit moves one place toward bit 0, `tdi` enters the highest bit, and `tdo` always shows bit 0.
- R4: On a rising `tck` with `dr_clk_en`=1 and `shift_dr`=0, all cells load in parallel. Input cells load their pad value. Drive and enable cells load the value currently presented on their pad output. The three fixed cells load 0.
- R5: Chain positions: bit 0 is the output-enable auxiliary cell and bit 1 is the output-data auxiliary cell. Bidirectional pin k uses bit 2+3k for its input, bit 3+3k for its drive value and bit 4+3k for its enable. Receive-only pin j uses bit 2+3·N_BIDIR+j. Drive-only pin j uses bit 2+3·N_BIDIR+N_IN+j. The last bit is the update-control cell.
- R6: Update stages load from their shift flip-flops only on a rising `tck` with `update_dr`=1. They hold through shifting and capture.
- R7: With `extest`=1, `pad_o`, `pad_oe` and `oo_pad` take the values in the update stages.
- R8: With `extest`=0, `pad_o`=`core_o`, `pad_oe`=`core_oe` and `oo_pad`=`oo_core`, whatever the chain contents.
- R9: `core_i` always equals `pad_i` and `in_core` always equals `in_pad`. The receive path is never intercepted.
- R10: `aux_tdo_oe`, `aux_tdo_d` and `aux_upd` present the update stages of bits 0, 1 and the last bit.
- R11: With `dr_clk_en`=0, the shift flip-flops hold regardless of `shift_dr` and `tdi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (bit 0) |
| dr_clk_en | input | 1 | Clock-DR enable for the shift flip-flops |
| shift_dr | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| update_dr | input | 1 | Update strobe |
| extest | input | 1 | External-test mode: update stages drive the pads |
| core_o | input | N_BIDIR | Core drive values for bidirectional pins |
| core_oe | input | N_BIDIR | Core driver enables for bidirectional pins |
| core_i | output | N_BIDIR | Pad values returned to the core |
| pad_i | input | N_BIDIR | Values received from the bidirectional pads |
| pad_o | output | N_BIDIR | Values driven to the bidirectional pads |
| pad_oe | output | N_BIDIR | Driver enables to the bidirectional pads |
| in_pad | input | N_IN | Receive-only pad values |
| in_core | output | N_IN | Receive-only values to the core |
| oo_core | input | N_OUT | Core values for drive-only pins |
| oo_pad | output | N_OUT | Values to the drive-only pads |
| aux_tdo_oe | output | 1 | Update stage of chain bit 0 |
| aux_tdo_d | output | 1 | Update stage of chain bit 1 |
| aux_upd | output | 1 | Update stage of the last chain bit |

## Verification
The hardest case to reach from the ports is a capture of drive and enable cells under external-test mode. The pads then show update-stage contents rather than core values, so a stale or wrongly routed capture is hidden unless those contents differ from both the core values and the current chain contents. The stimulus loads one pattern and updates it. It enters external-test mode, shifts a second pattern in without an update, and checks that the pads still show the first pattern. It then captures and shifts the result out, so every output-side cell must return the first pattern while the input cells return freshly changed pad values.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [2:0] {
    CK_TDO_EN,
    CK_TDO_DAT,
    CK_PIN_IN,
    CK_PIN_OUT,
    CK_PIN_EN,
    CK_IN_ONLY,
    CK_OUT_ONLY,
    CK_UPD_CTL
  } cell_kind_e;

  function automatic int chain_len(input int nb, input int ni, input int no);
    return 3 * nb + ni + no + 3;
  endfunction

  function automatic int pos_pin_in(input int k);
    return 2 + 3 * k;
  endfunction

  function automatic int pos_pin_out(input int k);
    return 3 + 3 * k;
  endfunction

  function automatic int pos_pin_en(input int k);
    return 4 + 3 * k;
  endfunction

  function automatic int pos_in_only(input int j, input int nb);
    return 2 + 3 * nb + j;
  endfunction

  function automatic int pos_out_only(input int j, input int nb, input int ni);
    return 2 + 3 * nb + ni + j;
  endfunction

  // Classifies chain bit i; the result selects the capture source of the cell.
  function automatic cell_kind_e kind_of(input int i, input int nb,
                                         input int ni, input int no);
    if (i == 0) return CK_TDO_EN;
    if (i == 1) return CK_TDO_DAT;
    if (i == chain_len(nb, ni, no) - 1) return CK_UPD_CTL;
    if (i < 2 + 3 * nb) begin
      case ((i - 2) % 3)
        0:       return CK_PIN_IN;
        1:       return CK_PIN_OUT;
        default: return CK_PIN_EN;
      endcase
    end
    if (i < 2 + 3 * nb + ni) return CK_IN_ONLY;
    return CK_OUT_ONLY;
  endfunction

endpackage

// File: rtl/bsc_scan_cell.sv
module bsc_scan_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic dr_clk_en,
  input  logic shift_dr,
  input  logic cap_d,
  input  logic ser_d,
  output logic sh_q
);

  logic mux_d;

  // Capture/shift selection ahead of the shift flip-flop.
  assign mux_d = shift_dr ? ser_d : cap_d;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        sh_q <= 1'b0;
    else if (dr_clk_en) sh_q <= mux_d;
  end

  a_r3_shift_step: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_clk_en && shift_dr) |=> (sh_q == $past(ser_d)));

  a_r4_capture_load: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_clk_en && !shift_dr) |=> (sh_q == $past(cap_d)));

  a_r11_hold_idle: assert property (@(posedge tck) disable iff (!trst_n)
    !dr_clk_en |=> $stable(sh_q));

endmodule

// File: rtl/bsc_update_bank.sv
module bsc_update_bank #(
  parameter int W = 4
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         update_dr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        q <= '0;
    else if (update_dr) q <= d;
  end

  a_r6_hold_between: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable(q));

  a_r6_load_on_strobe: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr |=> (q == $past(d)));

endmodule

// File: rtl/bsc_pad_mux.sv
module bsc_pad_mux #(
  parameter int W = 4
) (
  input  logic         extest,
  input  logic [W-1:0] core_v,
  input  logic [W-1:0] scan_v,
  output logic [W-1:0] pad_v
);

  always_comb begin
    pad_v = extest ? scan_v : core_v;
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_BIDIR = 4,
  parameter int N_IN    = 2,
  parameter int N_OUT   = 2
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  output logic               tdo,
  input  logic               dr_clk_en,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               extest,
  input  logic [N_BIDIR-1:0] core_o,
  input  logic [N_BIDIR-1:0] core_oe,
  output logic [N_BIDIR-1:0] core_i,
  input  logic [N_BIDIR-1:0] pad_i,
  output logic [N_BIDIR-1:0] pad_o,
  output logic [N_BIDIR-1:0] pad_oe,
  input  logic [N_IN-1:0]    in_pad,
  output logic [N_IN-1:0]    in_core,
  input  logic [N_OUT-1:0]   oo_core,
  output logic [N_OUT-1:0]   oo_pad,
  output logic               aux_tdo_oe,
  output logic               aux_tdo_d,
  output logic               aux_upd
);
  import bsc_pkg::*;

  localparam int L = chain_len(N_BIDIR, N_IN, N_OUT);

  logic [L-1:0]       sh;
  logic [L-1:0]       ser;
  logic [L-1:0]       cap;
  logic [N_BIDIR-1:0] out_sd, oe_sd, out_up, oe_up;
  logic [N_OUT-1:0]   oo_sd, oo_up;
  logic [2:0]         aux_sd, aux_up;

  // Serial path: tdi enters at the top, bit 0 leaves on tdo.
  assign ser = {tdi, sh[L-1:1]};
  assign tdo = sh[0];

  // Receive paths are only observed, never intercepted.
  assign core_i  = pad_i;
  assign in_core = in_pad;

  for (genvar i = 0; i < L; i++) begin : g_cell
    localparam cell_kind_e KIND = kind_of(i, N_BIDIR, N_IN, N_OUT);
    if (KIND == CK_PIN_IN) begin : g_pin_in
      assign cap[i] = pad_i[(i - 2) / 3];
    end else if (KIND == CK_PIN_OUT) begin : g_pin_out
      assign cap[i] = pad_o[(i - 3) / 3];
    end else if (KIND == CK_PIN_EN) begin : g_pin_en
      assign cap[i] = pad_oe[(i - 4) / 3];
    end else if (KIND == CK_IN_ONLY) begin : g_in_only
      assign cap[i] = in_pad[i - 2 - 3 * N_BIDIR];
    end else if (KIND == CK_OUT_ONLY) begin : g_out_only
      assign cap[i] = oo_pad[i - 2 - 3 * N_BIDIR - N_IN];
    end else begin : g_fixed
      assign cap[i] = 1'b0;
    end

    bsc_scan_cell u_cell (
      .tck       (tck),
      .trst_n    (trst_n),
      .dr_clk_en (dr_clk_en),
      .shift_dr  (shift_dr),
      .cap_d     (cap[i]),
      .ser_d     (ser[i]),
      .sh_q      (sh[i])
    );
  end

  for (genvar k = 0; k < N_BIDIR; k++) begin : g_bidir_tap
    assign out_sd[k] = sh[pos_pin_out(k)];
    assign oe_sd[k]  = sh[pos_pin_en(k)];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_oonly_tap
    assign oo_sd[j] = sh[pos_out_only(j, N_BIDIR, N_IN)];
  end

  assign aux_sd = {sh[L-1], sh[1], sh[0]};

  bsc_update_bank #(.W(N_BIDIR)) u_upd_out (
    .tck(tck), .trst_n(trst_n), .update_dr(update_dr), .d(out_sd), .q(out_up));

  bsc_update_bank #(.W(N_BIDIR)) u_upd_oe (
    .tck(tck), .trst_n(trst_n), .update_dr(update_dr), .d(oe_sd), .q(oe_up));

  bsc_update_bank #(.W(N_OUT)) u_upd_oo (
    .tck(tck), .trst_n(trst_n), .update_dr(update_dr), .d(oo_sd), .q(oo_up));

  bsc_update_bank #(.W(3)) u_upd_aux (
    .tck(tck), .trst_n(trst_n), .update_dr(update_dr), .d(aux_sd), .q(aux_up));

  bsc_pad_mux #(.W(N_BIDIR)) u_mux_out (
    .extest(extest), .core_v(core_o), .scan_v(out_up), .pad_v(pad_o));

  bsc_pad_mux #(.W(N_BIDIR)) u_mux_oe (
    .extest(extest), .core_v(core_oe), .scan_v(oe_up), .pad_v(pad_oe));

  bsc_pad_mux #(.W(N_OUT)) u_mux_oo (
    .extest(extest), .core_v(oo_core), .scan_v(oo_up), .pad_v(oo_pad));

  assign aux_tdo_oe = aux_up[0];
  assign aux_tdo_d  = aux_up[1];
  assign aux_upd    = aux_up[2];

  // R2: the top cell takes tdi one clock after a shift, so a bit needs L shifts to reach tdo.
  a_r2_entry_at_top: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_clk_en && shift_dr) |=> (sh[L-1] == $past(tdi)));

  a_r3_exit_at_bottom: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_clk_en && shift_dr) |=> (tdo == $past(sh[1])));

  a_r6_pads_steady_in_extest: assert property (@(posedge tck) disable iff (!trst_n)
    (extest && $past(extest) && !$past(update_dr)) |-> $stable(pad_o) && $stable(pad_oe));

endmodule

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int NB = 4;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam int L  = 3 * NB + NI + NO + 3;

  logic tck = 1'b0;
  logic trst_n, tdi, tdo, dr_clk_en, shift_dr, update_dr, extest;
  logic [NB-1:0] core_o, core_oe, core_i, pad_i, pad_o, pad_oe;
  logic [NI-1:0] in_pad, in_core;
  logic [NO-1:0] oo_core, oo_pad;
  logic aux_tdo_oe, aux_tdo_d, aux_upd;

  int n_tests = 0;
  int n_fail  = 0;
  logic [L-1:0] mdl;   // expected chain contents
  logic [L-1:0] lat;   // expected update-stage contents
  logic         exp_q[$];

  always #4 tck = ~tck;

  bscan_chain #(.N_BIDIR(NB), .N_IN(NI), .N_OUT(NO)) i_bscan_chain (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo), .dr_clk_en(dr_clk_en),
    .shift_dr(shift_dr), .update_dr(update_dr), .extest(extest),
    .core_o(core_o), .core_oe(core_oe), .core_i(core_i), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .in_pad(in_pad), .in_core(in_core),
    .oo_core(oo_core), .oo_pad(oo_pad), .aux_tdo_oe(aux_tdo_oe),
    .aux_tdo_d(aux_tdo_d), .aux_upd(aux_upd));

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares each shifted-out bit with the scoreboard queue.
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (exp_q.size() != 0) chk_eq("R3/R5 tdo bit order", {31'd0, tdo}, {31'd0, exp_q.pop_front()});
    end
  end

  // Driver: shifts n bits of v (v[0] first) and pushes expected tdo bits.
  task automatic shift_in(input logic [L-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge tck);
      tdi = v[i]; shift_dr = 1'b1; dr_clk_en = 1'b1;
      exp_q.push_back(mdl[0]);
      mdl = {v[i], mdl[L-1:1]};
    end
    @(negedge tck);
    dr_clk_en = 1'b0; shift_dr = 1'b0;
  endtask

  function automatic logic [L-1:0] capture_model();
    logic [L-1:0] v = '0;
    for (int k = 0; k < NB; k++) begin
      v[2 + 3*k] = pad_i[k];
      v[3 + 3*k] = extest ? lat[3 + 3*k] : core_o[k];
      v[4 + 3*k] = extest ? lat[4 + 3*k] : core_oe[k];
    end
    for (int j = 0; j < NI; j++) v[2 + 3*NB + j] = in_pad[j];
    for (int j = 0; j < NO; j++) v[2 + 3*NB + NI + j] = extest ? lat[2 + 3*NB + NI + j] : oo_core[j];
    return v;
  endfunction

  task automatic capture();
    @(negedge tck);
    shift_dr = 1'b0; dr_clk_en = 1'b1;
    mdl = capture_model();
    @(negedge tck);
    dr_clk_en = 1'b0;
  endtask

  task automatic update();
    @(negedge tck);
    update_dr = 1'b1;
    lat = mdl;
    @(negedge tck);
    update_dr = 1'b0;
  endtask

  task automatic check_pads(input string req);
    logic [NB-1:0] eo, ee;
    logic [NO-1:0] eoo;
    #1;
    for (int k = 0; k < NB; k++) begin
      eo[k] = extest ? lat[3 + 3*k] : core_o[k];
      ee[k] = extest ? lat[4 + 3*k] : core_oe[k];
    end
    for (int j = 0; j < NO; j++) eoo[j] = extest ? lat[2 + 3*NB + NI + j] : oo_core[j];
    chk_eq({req, " pad_o"},  {28'd0, pad_o},  {28'd0, eo});
    chk_eq({req, " pad_oe"}, {28'd0, pad_oe}, {28'd0, ee});
    chk_eq({req, " oo_pad"}, {30'd0, oo_pad}, {30'd0, eoo});
    chk_eq("R10 aux outputs", {29'd0, aux_upd, aux_tdo_d, aux_tdo_oe},
           {29'd0, lat[L-1], lat[1], lat[0]});
    chk_eq("R9 core_i", {28'd0, core_i}, {28'd0, pad_i});
    chk_eq("R9 in_core", {30'd0, in_core}, {30'd0, in_pad});
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tdi = 1'b0; dr_clk_en = 1'b0; shift_dr = 1'b0;
    update_dr = 1'b0; extest = 1'b0;
    core_o = 4'b1010; core_oe = 4'b1100; oo_core = 2'b01;
    pad_i = 4'b0110; in_pad = 2'b10;
    mdl = '0; lat = '0;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    #1;
    chk_eq("R1 tdo after reset", {31'd0, tdo}, 32'd0);
    check_pads("R1/R8 reset");

    // R2: a lone marker reaches tdo after exactly L shifts.
    shift_in({{(L-1){1'b0}}, 1'b1}, L - 1);
    #1 chk_eq("R2 marker not yet out", {31'd0, tdo}, 32'd0);
    shift_in('0, 1);
    #1 chk_eq("R2 marker at tdo after L shifts", {31'd0, tdo}, 32'd1);

    // R3/R5: pattern in, then out under a second pattern.
    shift_in(19'h5B3C6, L);
    update();
    extest = 1'b1;
    check_pads("R7 extest drive");

    // R6: new pattern shifted without update leaves pads unchanged.
    shift_in(19'h2A4D9, L);
    check_pads("R6 no update during shift");

    // R11: no clock-DR enable, chain holds.
    @(negedge tck);
    shift_dr = 1'b1; tdi = ~mdl[L-1];
    repeat (5) @(negedge tck);
    shift_dr = 1'b0;
    #1 chk_eq("R11 tdo held", {31'd0, tdo}, {31'd0, mdl[0]});
    shift_in(19'h71E0F, L);

    // R8: functional path with chain loaded.
    extest = 1'b0;
    check_pads("R8 passthrough");

    // R4/R5: capture in functional mode, shift out.
    capture();
    shift_in(19'h0F0F3, L);

    // R4/R7: load, update, extest, change pads, capture latched outputs.
    update();
    extest = 1'b1;
    shift_in(19'h36A95, L);
    pad_i = 4'b1001; in_pad = 2'b01; core_o = 4'b0101; oo_core = 2'b10;
    check_pads("R6/R7 extest after reshift");
    capture();
    shift_in(19'h13579, L);
    update();
    check_pads("R7 final update");

    repeat (2) @(negedge tck);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule